// File: doc/BRIEF.md
# Rotating-Slot Shared Resource Arbiter

The block lets eight processor cores share one memory and a small bank of semaphore bits without any of them ever contending. A three-bit owner counter names one core each clock and moves on every clock, whether or not that core has anything to do. Only the current owner can touch the memory or the semaphores, so every access is exclusive. A read-modify-write of a semaphore bit finishes inside one slot, which makes it atomic.

A core raises its request with an operation code, an address and write data. It keeps them steady until it sees its acknowledge. The acknowledge is a single-clock pulse in the cycle after the core's slot, and the response word is on the shared read-data bus in that same cycle. Because slots rotate blindly, a core waits at most eight clocks, and that wait does not depend on what the other seven cores are doing.

A small response state machine decides what the read-data bus carries. Its states are RSP_IDLE (nothing returned, no acknowledge), RSP_MEM (the memory word), RSP_LOCK (the previous semaphore value) and RSP_ZERO (zero, after a write or a release). It re-decides on every clock from whatever is granted in the current slot. A granted read moves it to RSP_MEM, a granted lock-take to RSP_LOCK, and a granted write or release to RSP_ZERO. An idle owner sends it to RSP_IDLE. Any state can move to any other on any clock.

Top module: `slot_arbiter`

## Requirements
- R1: The first clock after reset belongs to core 0. The owner then steps by one every clock, wrapping from 7 to 0, with or without requests.
- R2: A request from core i is carried out only at the clock edge that ends one of core i's slots. `ack[i]` is high in the cycle after that edge, and `ack` never has more than one bit set.
- R3: A slot whose owner is idle is never given to another core, so a core that asks just after its slot has passed waits exactly eight clocks.
- R4: An acknowledge lasts exactly one cycle.
- R5: Operation code 01 (write) stores the write data at the request's address. The response word is 0.
- R6: Operation code 00 (read) returns the addressed word in the acknowledge cycle. This includes a write made by another core in an earlier slot of the same rotation.
- R7: Operation code 10 (lock take) returns the previous value of semaphore bit addr[3:0] in rdata[0], with all upper bits 0, and leaves that bit set.
- R8: Operation code 11 (lock release) clears semaphore bit addr[3:0], and its response word is 0.
- R9: When several cores take the same semaphore in one rotation, the one whose slot comes first after the requests appear gets 0 and the others get 1. Core numbering gives no priority.
- R10: During and right after reset, `ack` is all zero, `rdata` is 0, and every semaphore bit is clear.
- R11: With all eight cores requesting at once, each is served in its own slot, no later than eight clocks after asking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-core request, held until acknowledged |
| req_op | input | 16 | Per-core 2-bit operation code, core i at [2i+1:2i] |
| req_addr | input | 48 | Per-core 6-bit word address, core i at [6i+5:6i] |
| req_wdata | input | 256 | Per-core 32-bit write data, core i at [32i+31:32i] |
| ack | output | 8 | One-cycle acknowledge, one-hot by core |
| rdata | output | 32 | Response word, valid while any ack bit is high |

## Verification
Each core is first driven alone, doing writes and then reads. This separates slot placement from data handling. Next, all eight cores request at once. This shows that heavy load moves nobody's slot and that no acknowledge lands in a wrong slot. A request made just after its own slot has passed, while the next owner sits idle, tells blind rotation apart from work-conserving arbitration. The contention patterns cover a write followed by a read of the same word in one rotation, and two cores taking one semaphore with the request timing reversed. Together they show that ordering follows the slot sequence and not the core number.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_TAKE  = 2'b10,
        OP_FREE  = 2'b11
    } acc_op_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'b00,
        RSP_MEM  = 2'b01,
        RSP_LOCK = 2'b10,
        RSP_ZERO = 2'b11
    } rsp_state_e;

endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int NCORE = 8,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] owner
);

    localparam logic [SW-1:0] LAST = SW'(NCORE - 1);

    // Blind rotation: steps every clock, requests are never consulted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= '0;
        end else if (owner == LAST) begin
            owner <= '0;
        end else begin
            owner <= owner + 1'b1;
        end
    end

endmodule

// File: rtl/owner_select.sv
module owner_select
    import slot_arb_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int AW    = 6,
    parameter int DW    = 32,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic [SW-1:0]       owner,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [NCORE*2-1:0]  req_op,
    input  logic [NCORE*AW-1:0] req_addr,
    input  logic [NCORE*DW-1:0] req_wdata,
    output logic                sel_valid,
    output acc_op_e             sel_op,
    output logic [AW-1:0]       sel_addr,
    output logic [DW-1:0]       sel_wdata
);

    logic [1:0]    op_arr   [NCORE];
    logic [AW-1:0] addr_arr [NCORE];
    logic [DW-1:0] data_arr [NCORE];

    // Unpack the flattened per-core buses.
    for (genvar c = 0; c < NCORE; c++) begin : g_unpack
        assign op_arr[c]   = req_op[c*2 +: 2];
        assign addr_arr[c] = req_addr[c*AW +: AW];
        assign data_arr[c] = req_wdata[c*DW +: DW];
    end

    // Only the slot owner's request is looked at.
    always_comb begin
        sel_valid = req_valid[owner];
        sel_op    = acc_op_e'(op_arr[owner]);
        sel_addr  = addr_arr[owner];
        sel_wdata = data_arr[owner];
    end

endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
    parameter int NLOCK = 16,
    localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             free,
    input  logic [LW-1:0]    idx,
    output logic             prev_q,
    output logic [NLOCK-1:0] locks
);

    // Read and update in the same edge: the slot makes it atomic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locks  <= '0;
            prev_q <= 1'b0;
        end else begin
            if (take) begin
                prev_q     <= locks[idx];
                locks[idx] <= 1'b1;
            end else if (free) begin
                locks[idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/shared_ram.sv
module shared_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[addr];
        end
    end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int NCORE     = 8,
    parameter int RAM_DEPTH = 64,
    parameter int DW        = 32,
    parameter int NLOCK     = 16,
    localparam int AW = $clog2(RAM_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [NCORE*2-1:0]  req_op,
    input  logic [NCORE*AW-1:0] req_addr,
    input  logic [NCORE*DW-1:0] req_wdata,
    output logic [NCORE-1:0]    ack,
    output logic [DW-1:0]       rdata
);

    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1;

    logic [SW-1:0] owner;
    logic          sel_valid;
    acc_op_e       sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic          lock_prev;
    logic [NLOCK-1:0] locks;
    logic [DW-1:0] ram_q;
    logic [LW-1:0] lock_idx;

    logic do_read, do_write, do_take, do_free;

    rsp_state_e    rsp_q, rsp_d;
    logic [SW-1:0] rsp_core_q;

    slot_counter #(.NCORE(NCORE)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .owner (owner)
    );

    owner_select #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_sel (
        .owner     (owner),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_valid (sel_valid),
        .sel_op    (sel_op),
        .sel_addr  (sel_addr),
        .sel_wdata (sel_wdata)
    );

    assign lock_idx = sel_addr[LW-1:0];

    always_comb begin
        do_read  = sel_valid && (sel_op == OP_READ);
        do_write = sel_valid && (sel_op == OP_WRITE);
        do_take  = sel_valid && (sel_op == OP_TAKE);
        do_free  = sel_valid && (sel_op == OP_FREE);
    end

    shared_ram #(.DEPTH(RAM_DEPTH), .DW(DW)) u_ram (
        .clk     (clk),
        .we      (do_write),
        .re      (do_read),
        .addr    (sel_addr),
        .wdata   (sel_wdata),
        .rdata_q (ram_q)
    );

    lock_bank #(.NLOCK(NLOCK)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (do_take),
        .free   (do_free),
        .idx    (lock_idx),
        .prev_q (lock_prev),
        .locks  (locks)
    );

    // Response state for the next cycle, chosen from this slot's grant.
    always_comb begin
        rsp_d = RSP_IDLE;
        if (sel_valid) begin
            unique case (sel_op)
                OP_READ:  rsp_d = RSP_MEM;
                OP_TAKE:  rsp_d = RSP_LOCK;
                OP_WRITE: rsp_d = RSP_ZERO;
                OP_FREE:  rsp_d = RSP_ZERO;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= RSP_IDLE;
            rsp_core_q <= '0;
        end else begin
            rsp_q      <= rsp_d;
            rsp_core_q <= owner;
        end
    end

    // Outputs from state.
    always_comb begin
        ack   = '0;
        rdata = '0;
        unique case (rsp_q)
            RSP_IDLE: begin
                ack   = '0;
                rdata = '0;
            end
            RSP_MEM: begin
                ack[rsp_core_q] = 1'b1;
                rdata           = ram_q;
            end
            RSP_LOCK: begin
                ack[rsp_core_q] = 1'b1;
                rdata           = {{(DW-1){1'b0}}, lock_prev};
            end
            RSP_ZERO: begin
                ack[rsp_core_q] = 1'b1;
                rdata           = '0;
            end
        endcase
    end

endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
    parameter int NCORE = 8,
    parameter int NLOCK = 16,
    localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SW-1:0]    owner,
    input logic [NCORE-1:0] ack,
    input logic [NCORE-1:0] req_valid,
    input logic             do_take,
    input logic             do_free,
    input logic [LW-1:0]    lock_idx,
    input logic [NLOCK-1:0] locks
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_first_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> owner == '0);

    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> owner == (($past(owner) == SW'(NCORE - 1)) ? '0 : SW'($past(owner) + 1'b1)));

    a_r2_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    a_r2_ack_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ack != '0) |-> ack == (NCORE'(1) << $past(owner)));

    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (ack & ~$past(req_valid)) == '0);

    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (ack & $past(ack)) == '0);

    a_r7_take_sets: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> locks[$past(lock_idx)]);

    a_r8_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
        do_free |=> !locks[$past(lock_idx)]);

endmodule

bind slot_arbiter slot_arbiter_chk #(.NCORE(NCORE), .NLOCK(NLOCK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (owner),
    .ack       (ack),
    .req_valid (req_valid),
    .do_take   (do_take),
    .do_free   (do_free),
    .lock_idx  (lock_idx),
    .locks     (locks)
);

// File: tb/sim_slot_arbiter.sv
module sim_slot_arbiter;

    localparam int NC = 8;
    localparam int AW = 6;
    localparam int DW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    req_valid = '0;
    logic [NC*2-1:0]  req_op = '0;
    logic [NC*AW-1:0] req_addr = '0;
    logic [NC*DW-1:0] req_wdata = '0;
    logic [NC-1:0]    ack;
    logic [DW-1:0]    rdata;

    int n_chk = 0;
    int n_bad = 0;
    int ecount = 0;
    logic [NC-1:0] pend = '0;
    logic [DW-1:0] expd [NC];
    int lat [NC];

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    slot_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_req(input int c, input logic [1:0] op, input int a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] exp);
        req_valid[c]          = 1'b1;
        req_op[c*2 +: 2]      = op;
        req_addr[c*AW +: AW]  = AW'(a);
        req_wdata[c*DW +: DW] = wd;
        pend[c]               = 1'b1;
        expd[c]               = exp;
    endtask

    task automatic sync_to(input int k);
        while (ecount % 8 != k) @(negedge clk);
    endtask

    // Poll until every pending request is acknowledged; check slot, data, latency.
    task automatic run_round(input string req);
        int start = ecount;
        for (int cyc = 0; cyc < 20 && pend != '0; cyc++) begin
            @(negedge clk);
            chk((ack & ~pend) == '0, "R4", "ack without pending request", DW'(ack), DW'(ack & pend));
            for (int c = 0; c < NC; c++) begin
                if (ack[c] && pend[c]) begin
                    chk(ack == NC'(1) << c, "R2", "ack one-hot", DW'(ack), DW'(NC'(1) << c));
                    chk((ecount - 1) % 8 == c, "R2", "served slot", DW'((ecount - 1) % 8), DW'(c));
                    chk(rdata == expd[c], req, "response word", rdata, expd[c]);
                    lat[c] = ecount - start;
                    chk(lat[c] >= 1 && lat[c] <= 8, "R11", "latency", DW'(lat[c]), 32'd8);
                    pend[c] = 1'b0;
                    req_valid[c] = 1'b0;
                end
            end
        end
        chk(pend == '0, req, "requests left unserved", DW'(pend), 32'd0);
        pend = '0;
        req_valid = '0;
        @(negedge clk);
        chk(ack == '0, "R4", "ack after pulse", DW'(ack), 32'd0);
    endtask

    task automatic t_reset;
        chk(ack == '0, "R10", "ack in reset", DW'(ack), 32'd0);
        chk(rdata == '0, "R10", "rdata in reset", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == '0, "R10", "ack after reset", DW'(ack), 32'd0);
    endtask

    task automatic t_solo;
        for (int c = 0; c < NC; c++) begin
            set_req(c, 2'b01, c + 1, 32'hA000 + c, 32'd0);  // R5 write
            run_round("R5");
        end
        for (int c = NC - 1; c >= 0; c--) begin
            set_req(c, 2'b00, NC - c, 32'd0, 32'hA000 + (NC - 1 - c));  // R6 read back
            run_round("R6");
        end
    endtask

    task automatic t_no_early;
        sync_to(4);  // next edge is core 4's slot, core 4 idle
        set_req(3, 2'b00, 4, 32'd0, 32'hA003);
        run_round("R3");
        chk(lat[3] == 8, "R3", "idle slot not lent", DW'(lat[3]), 32'd8);
        sync_to(1);  // R1: slot sequence continues one per clock
        set_req(1, 2'b00, 2, 32'd0, 32'hA001);
        run_round("R1");
        chk(lat[1] == 1, "R1", "own slot next edge", DW'(lat[1]), 32'd1);
    endtask

    task automatic t_all;
        for (int c = 0; c < NC; c++) set_req(c, 2'b00, c + 1, 32'd0, 32'hA000 + c);
        run_round("R11");
    endtask

    task automatic t_same_round;
        sync_to(0);
        set_req(3, 2'b01, 20, 32'h5555_1234, 32'd0);
        set_req(4, 2'b00, 20, 32'd0, 32'h5555_1234);
        run_round("R6");
    endtask

    task automatic t_lock;
        set_req(2, 2'b10, 21, 32'd0, 32'd0);   // R10 locks clear; R7 index = addr[3:0] = 5
        run_round("R7");
        set_req(4, 2'b10, 5, 32'd0, 32'd1);
        run_round("R7");
        set_req(2, 2'b11, 5, 32'd0, 32'd0);
        run_round("R8");
        set_req(6, 2'b10, 37, 32'd0, 32'd0);
        run_round("R8");
    endtask

    task automatic t_contend;
        sync_to(0);
        set_req(1, 2'b10, 7, 32'd0, 32'd0);
        set_req(2, 2'b10, 7, 32'd0, 32'd1);
        run_round("R9");
        sync_to(2);  // core 2 first this time
        set_req(1, 2'b10, 9, 32'd0, 32'd1);
        set_req(2, 2'b10, 9, 32'd0, 32'd0);
        run_round("R9");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_solo();
        t_no_early();
        t_all();
        t_same_round();
        t_lock();
        t_contend();
        summary();
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

endmodule